// File: doc/BRIEF.md
# Inter-Processor Mailbox

This block lets a host processor and a remote agent exchange 32-bit words through two small queues. The host sees a word-addressed register port with four live registers. A read of the receive register takes the oldest word from the inbound queue. A write to the send register adds a word to the outbound queue. A status register reports both queue flags, the inbound fill level and a sticky drop flag. A config register enables an interrupt. The remote agent drains the outbound queue and fills the inbound queue through two valid/ready streams.

By convention each word carries a logical channel in its low nibble and a 28-bit payload above it. The block stores and forwards words without change. It decodes the channel only to expose the channel of the inbound head word, and a flag when that channel is the property channel (8 by default). The rest of the word has no meaning to the block. Register word indices are 0 (receive), 6 (status), 7 (config) and 8 (send); the byte offset is four times the index.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset both queues are empty, status reads 0x4000_0000, config reads 0, `irq`, `out_valid` and `rsp_valid` are low and `in_ready` is high.
- R2: Every request with `req_valid` high is accepted (`req_ready` is always high). `rsp_valid` is high in exactly the following cycle, and `rsp_rdata` is 0 for writes.
- R3: A write to index 8 appends `req_wdata` unchanged to the outbound queue. The remote side sees words in arrival order on `out_data` while `out_valid` is high, and each cycle with `out_ready` high removes one word.
- R4: A write to index 8 while the outbound queue holds DEPTH words is dropped and sets the sticky drop flag in status bit 8. Writing status with bit 8 set clears the flag. No other status bit is writable.
- R5: The inbound queue takes `in_data` in each cycle where `in_valid` and `in_ready` are both high, and `in_ready` is low exactly when it holds DEPTH words. A read of index 0 returns the oldest inbound word and removes it.
- R6: A read of index 0 while the inbound queue is empty returns 0 and leaves the queue unchanged.
- R7: The status word has these fields: bit 31 is outbound full, bit 30 is inbound empty, bit 8 is the drop flag, and bits [7:0] hold the inbound fill level (0 to DEPTH). All other bits read 0.
- R8: Config bit 0 is read/write and the other config bits read 0. `irq` is high exactly while config bit 0 is set and the inbound queue is not empty.
- R9: Indices 1 to 5 and 9 to 15 read 0 and ignore writes. A write to index 0 and a read of index 8 have no effect, and the read returns 0.
- R10: `peek_chan` shows bits [3:0] of the inbound head word and is 0 when the queue is empty. `peek_prop` is high when the queue is not empty and that channel equals PROP_CHAN.
- R11: A host pop and a remote push in the same cycle both take effect and the inbound level is unchanged. The same holds for a host write and a remote drain of the outbound queue. Whether a push is accepted depends on the level before that cycle, so nothing enters a full queue even when it drains in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Always high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_widx | input | IDX_W | Register word index |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| out_valid | output | 1 | Outbound queue holds a word |
| out_ready | input | 1 | Remote takes the outbound head word |
| out_data | output | 32 | Outbound head word |
| in_valid | input | 1 | Remote offers a word |
| in_ready | output | 1 | Inbound queue has room |
| in_data | input | 32 | Word offered by the remote |
| peek_chan | output | 4 | Channel of the inbound head word |
| peek_prop | output | 1 | Inbound head word is on the property channel |
| irq | output | 1 | Inbound-not-empty interrupt |

## Verification
Two operations can land in the same cycle on one queue: a host read of the receive register together with a remote push, and a host write of the send register together with a remote drain. The bench drives both sides in the same cycle at a partial level and again at the full level. It then reads status to confirm the fill level and drains the queue to confirm which words survived and in what order. At the full level, the new word must be refused and, on the send side, the drop flag must be set.

// File: rtl/xmbox_pkg.sv
package xmbox_pkg;

  localparam int WORD_W = 32;
  localparam int CHAN_W = 4;

  // register word indices
  localparam int IDX_RECV = 0;
  localparam int IDX_STAT = 6;
  localparam int IDX_CFG  = 7;
  localparam int IDX_SEND = 8;

  // status bit positions
  localparam int ST_OB_FULL  = 31;
  localparam int ST_IB_EMPTY = 30;
  localparam int ST_DROP     = 8;

  function automatic logic [WORD_W-1:0] mbx_pack(input logic [CHAN_W-1:0] chan,
                                                 input logic [WORD_W-1:0] payload);
    return {payload[WORD_W-1:CHAN_W], chan};
  endfunction

  function automatic logic [CHAN_W-1:0] mbx_chan(input logic [WORD_W-1:0] w);
    return w[CHAN_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] mbx_payload(input logic [WORD_W-1:0] w);
    return {w[WORD_W-1:CHAN_W], {CHAN_W{1'b0}}};
  endfunction

  function automatic logic [WORD_W-1:0] mbx_status(input logic ob_full,
                                                   input logic ib_empty,
                                                   input logic drop,
                                                   input logic [7:0] ib_level);
    logic [WORD_W-1:0] s;
    s = '0;
    s[ST_OB_FULL]  = ob_full;
    s[ST_IB_EMPTY] = ib_empty;
    s[ST_DROP]     = drop;
    s[7:0]         = ib_level;
    return s;
  endfunction

endpackage

// File: rtl/xmbox_fifo.sv
module xmbox_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_req,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty,
  output logic [LVL_W-1:0] level
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             push_fire, pop_fire;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (level == LVL_W'(DEPTH));
  assign empty     = (level == '0);
  assign push_fire = push_req && !full;
  assign pop_fire  = pop_req && !empty;
  assign head      = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_fire) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_fire) wr_ptr <= ptr_next(wr_ptr);
      if (pop_fire)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_fire, pop_fire})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  assert_full_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop_req) |=> full);

  assert_empty_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push_req) |=> empty);

  assert_both_fire_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && pop_fire) |=> $stable(level));

endmodule

// File: rtl/xmbox_regs.sv
module xmbox_regs
  import xmbox_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int LVL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [IDX_W-1:0]  req_widx,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  input  logic              ob_full,
  input  logic              ib_empty,
  input  logic [LVL_W-1:0]  ib_level,
  input  logic [WORD_W-1:0] ib_head,
  output logic              ob_push,
  output logic [WORD_W-1:0] ob_push_data,
  output logic              ib_pop,
  output logic              cfg_irq_en
);

  logic              hit_recv, hit_stat, hit_cfg, hit_send;
  logic              wr_req, rd_req;
  logic              drop_evt, drop_clr, drop_flag;
  logic [WORD_W-1:0] rd_val;

  assign hit_recv = (req_widx == IDX_W'(IDX_RECV));
  assign hit_stat = (req_widx == IDX_W'(IDX_STAT));
  assign hit_cfg  = (req_widx == IDX_W'(IDX_CFG));
  assign hit_send = (req_widx == IDX_W'(IDX_SEND));

  assign wr_req = req_valid && req_write;
  assign rd_req = req_valid && !req_write;

  assign ob_push      = wr_req && hit_send;
  assign ob_push_data = req_wdata;
  assign ib_pop       = rd_req && hit_recv;
  assign drop_evt     = ob_push && ob_full;
  assign drop_clr     = wr_req && hit_stat && req_wdata[ST_DROP];

  always_comb begin
    rd_val = '0;
    if (rd_req) begin
      if (hit_recv)      rd_val = ib_empty ? '0 : ib_head;
      else if (hit_stat) rd_val = mbx_status(ob_full, ib_empty, drop_flag, 8'(ib_level));
      else if (hit_cfg)  rd_val = {{(WORD_W-1){1'b0}}, cfg_irq_en};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drop_flag  <= 1'b0;
      cfg_irq_en <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      if (drop_evt)      drop_flag <= 1'b1;
      else if (drop_clr) drop_flag <= 1'b0;
      if (wr_req && hit_cfg) cfg_irq_en <= req_wdata[0];
      rsp_valid <= req_valid;
      rsp_rdata <= rd_val;
    end
  end

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_write_rsp_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> (rsp_rdata == '0));

  assert_drop_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> drop_flag);

  assert_drop_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_flag && !drop_clr) |=> drop_flag);

  assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_pop && ib_empty) |=> (rsp_rdata == '0));

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import xmbox_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int IDX_W     = 4,
  parameter int PROP_CHAN = 8,
  localparam int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [IDX_W-1:0]  req_widx,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic [CHAN_W-1:0] peek_chan,
  output logic              peek_prop,
  output logic              irq
);

  logic              ob_push, ob_full, ob_empty;
  logic [WORD_W-1:0] ob_push_data;
  logic [LVL_W-1:0]  ob_level;
  logic              ib_pop, ib_full, ib_empty;
  logic [WORD_W-1:0] ib_head;
  logic [LVL_W-1:0]  ib_level;
  logic              cfg_irq_en;

  assign req_ready = 1'b1;

  xmbox_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_ob_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (ob_push),
    .push_data (ob_push_data),
    .pop_req   (out_ready),
    .head      (out_data),
    .full      (ob_full),
    .empty     (ob_empty),
    .level     (ob_level)
  );

  xmbox_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_ib_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (in_valid),
    .push_data (in_data),
    .pop_req   (ib_pop),
    .head      (ib_head),
    .full      (ib_full),
    .empty     (ib_empty),
    .level     (ib_level)
  );

  xmbox_regs #(.IDX_W(IDX_W), .LVL_W(LVL_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_widx     (req_widx),
    .req_wdata    (req_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .ob_full      (ob_full),
    .ib_empty     (ib_empty),
    .ib_level     (ib_level),
    .ib_head      (ib_head),
    .ob_push      (ob_push),
    .ob_push_data (ob_push_data),
    .ib_pop       (ib_pop),
    .cfg_irq_en   (cfg_irq_en)
  );

  assign out_valid = !ob_empty;
  assign in_ready  = !ib_full;
  assign peek_chan = mbx_chan(ib_head);
  assign peek_prop = !ib_empty && (peek_chan == CHAN_W'(PROP_CHAN));
  assign irq       = cfg_irq_en && !ib_empty;

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_irq_en |-> !irq);

  assert_peek_prop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    peek_prop |-> (ib_level != '0));

  assert_in_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (ib_level == LVL_W'(DEPTH)));

  assert_out_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (ob_level != '0));

endmodule

// File: tb/test_ipc_mailbox.sv
module test_ipc_mailbox;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [3:0]  req_widx = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [3:0]  peek_chan;
  logic        peek_prop;
  logic        irq;

  int checks = 0;
  int errors = 0;

  ipc_mailbox #(.DEPTH(DEPTH)) i_ipc_mailbox (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_widx(req_widx), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .peek_chan(peek_chan), .peek_prop(peek_prop), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] ob_word(input int i);
    return ((32'h00AB_C000 + 32'(i)) << 4) | 32'(i % 16);
  endfunction

  function automatic logic [3:0] ib_chan(input int n);
    return (n % 3 == 0) ? 4'd8 : 4'(n % 16);
  endfunction

  function automatic logic [31:0] ib_word(input int n);
    return ((32'h0000_5500 + 32'(n)) << 4) | 32'(ib_chan(n));
  endfunction

  function automatic logic [31:0] st(input bit wfull, input bit rempty, input bit drop,
                                     input int lvl);
    return (32'(wfull) << 31) | (32'(rempty) << 30) | (32'(drop) << 8) | 32'(lvl);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic reg_op(input bit wr, input int widx, input logic [31:0] wd,
                        output logic [31:0] rd);
    req_valid = 1'b1; req_write = wr; req_widx = 4'(widx); req_wdata = wd;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk("R2 rsp_valid", 32'(rsp_valid), 32'd1);
    rd = rsp_rdata;
  endtask

  task automatic push_in(input logic [31:0] w);
    in_valid = 1'b1; in_data = w;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 in_ready", 32'(in_ready), 1);
    chk("R1 irq", 32'(irq), 0);
    chk("R2 req_ready", 32'(req_ready), 1);
    reg_op(1'b0, 6, 0, rd); chk("R1 status", rd, 32'h4000_0000);
    reg_op(1'b0, 7, 0, rd); chk("R1 config", rd, 0);
    reg_op(1'b1, 7, 0, rd); chk("R2 write rsp zero", rd, 0);

    // R3 R7 fill outbound
    for (int i = 0; i < DEPTH; i++) begin
      reg_op(1'b1, 8, ob_word(i), rd);
      reg_op(1'b0, 6, 0, rd);
      chk("R7 status while filling", rd, st(i + 1 == DEPTH, 1, 0, 0));
    end
    // R4 overflow drop
    reg_op(1'b1, 8, ob_word(99), rd);
    reg_op(1'b0, 6, 0, rd); chk("R4 drop flag set", rd, st(1, 1, 1, 0));
    reg_op(1'b1, 6, 32'hFFFF_FEFF, rd);
    reg_op(1'b0, 6, 0, rd); chk("R4 status not writable", rd, st(1, 1, 1, 0));
    reg_op(1'b1, 6, 32'h0000_0100, rd);
    reg_op(1'b0, 6, 0, rd); chk("R4 drop flag cleared", rd, st(1, 1, 0, 0));
    // R3 drain in order
    out_ready = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      chk("R3 out_valid", 32'(out_valid), 1);
      chk("R3 out_data order", out_data, ob_word(i));
      @(posedge clk); @(negedge clk);
    end
    chk("R3 drained", 32'(out_valid), 0);
    out_ready = 1'b0;

    // R5 R7 R10 inbound fill sweep
    for (int n = 0; n <= DEPTH; n++) begin
      reg_op(1'b0, 6, 0, rd);
      chk("R7 inbound level", rd, st(0, n == 0, 0, n));
      chk("R5 in_ready", 32'(in_ready), 32'(n != DEPTH));
      chk("R10 peek_chan", 32'(peek_chan), (n == 0) ? 0 : 32'(ib_chan(0)));
      chk("R10 peek_prop", 32'(peek_prop), (n == 0) ? 0 : 1);
      if (n < DEPTH) push_in(ib_word(n));
    end
    push_in(ib_word(50));
    reg_op(1'b0, 6, 0, rd); chk("R5 full refuses push", rd, st(0, 0, 0, DEPTH));

    // R8 interrupt enable
    chk("R8 irq disabled", 32'(irq), 0);
    reg_op(1'b1, 7, 32'hFFFF_FFFF, rd);
    reg_op(1'b0, 7, 0, rd); chk("R8 config readback", rd, 1);
    chk("R8 irq enabled", 32'(irq), 1);

    // R9 reserved indices
    for (int k = 1; k < 16; k++) begin
      if (k >= 6 && k <= 8) continue;
      reg_op(1'b1, k, 32'hFFFF_FFFF, rd);
      reg_op(1'b0, k, 0, rd); chk("R9 reserved reads zero", rd, 0);
    end
    reg_op(1'b1, 0, 32'h0, rd);
    reg_op(1'b0, 8, 0, rd); chk("R9 send reads zero", rd, 0);
    chk("R9 outbound untouched", 32'(out_valid), 0);
    reg_op(1'b0, 6, 0, rd); chk("R9 status untouched", rd, st(0, 0, 0, DEPTH));
    reg_op(1'b0, 7, 0, rd); chk("R9 config untouched", rd, 1);

    // R5 R10 pop in order
    for (int n = 0; n < DEPTH; n++) begin
      chk("R10 peek_chan head", 32'(peek_chan), 32'(ib_chan(n)));
      chk("R10 peek_prop head", 32'(peek_prop), 32'(ib_chan(n) == 4'd8));
      reg_op(1'b0, 0, 0, rd); chk("R5 receive order", rd, ib_word(n));
    end
    chk("R8 irq off when empty", 32'(irq), 0);
    // R6 empty read
    reg_op(1'b0, 0, 0, rd); chk("R6 empty read zero", rd, 0);
    reg_op(1'b0, 6, 0, rd); chk("R6 still empty", rd, st(0, 1, 0, 0));
    push_in(ib_word(20));
    reg_op(1'b0, 0, 0, rd); chk("R6 queue intact", rd, ib_word(20));

    // R11 inbound pop + push same cycle, partial level
    for (int n = 30; n < 33; n++) push_in(ib_word(n));
    req_valid = 1'b1; req_write = 1'b0; req_widx = 4'd0;
    in_valid = 1'b1; in_data = ib_word(33);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; in_valid = 1'b0;
    chk("R11 pop with push data", rsp_rdata, ib_word(30));
    reg_op(1'b0, 6, 0, rd); chk("R11 level unchanged", rd, st(0, 0, 0, 3));
    for (int n = 34; n < 39; n++) push_in(ib_word(n));
    // R11 at full level: push refused
    req_valid = 1'b1; req_write = 1'b0; req_widx = 4'd0;
    in_valid = 1'b1; in_data = ib_word(39);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; in_valid = 1'b0;
    chk("R11 pop at full", rsp_rdata, ib_word(31));
    reg_op(1'b0, 6, 0, rd); chk("R11 full push refused", rd, st(0, 0, 0, DEPTH - 1));
    for (int n = 32; n < 39; n++) begin
      reg_op(1'b0, 0, 0, rd); chk("R11 inbound survivors", rd, ib_word(n));
    end

    // R11 outbound write + drain at full level
    for (int i = 0; i < DEPTH; i++) reg_op(1'b1, 8, ob_word(40 + i), rd);
    req_valid = 1'b1; req_write = 1'b1; req_widx = 4'd8; req_wdata = ob_word(60);
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; out_ready = 1'b0;
    reg_op(1'b0, 6, 0, rd); chk("R11 R4 drop at full with drain", rd, st(0, 1, 1, 0));
    out_ready = 1'b1;
    for (int i = 1; i < DEPTH; i++) begin
      chk("R11 outbound survivors", out_data, ob_word(40 + i));
      @(posedge clk); @(negedge clk);
    end
    chk("R11 dropped word absent", 32'(out_valid), 0);
    out_ready = 1'b0;

    // R11 outbound write + drain at partial level
    for (int i = 70; i < 73; i++) reg_op(1'b1, 8, ob_word(i), rd);
    req_valid = 1'b1; req_write = 1'b1; req_widx = 4'd8; req_wdata = ob_word(73);
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    for (int i = 71; i < 74; i++) begin
      chk("R11 outbound write with drain", out_data, ob_word(i));
      @(posedge clk); @(negedge clk);
    end
    chk("R11 outbound empty after", 32'(out_valid), 0);
    out_ready = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule